// File: doc/BRIEF.md
# Selectable Square-Wave Clock Output

This block turns a slow, free-running 32.768 kHz reference square wave into a clock output at one of three rates: the reference itself, 1024 Hz, or 1 Hz. The reference arrives on an asynchronous input and is brought into the system clock domain. Each rising edge of the reference advances a 15-bit divider that runs freely. Two bits of the divider supply the slower rates.

A 2-bit rate code chooses the rate. An external enable input decides whether the output is driven at all. When the enable is low, the output is off. The off state models a high-impedance pad and is reported on a separate output-enable signal, with the clock value held low.

The rate code is captured only on reference rising edges. At power-on it starts at the full-rate code, so the reference is passed through until the first captured edge.

Top module: `rate_clkout`

## Requirements
- R1: While the synchronized enable is low, `clk_oe` is 0 and `clk_val` is 0, whatever `rate_sel` holds.
- R2: `clk_oe` equals the value `en_in` held two system clocks earlier, through a two-stage synchronizer.
- R3: With the enable high and a captured rate code of 2'b00, `clk_val` reproduces the reference level that `osc_in` held three system clocks earlier.
- R4: With the enable high and a captured rate code of 2'b01, `clk_val` is bit 4 of the edge counter. It changes once every 16 reference rising edges, with 50% duty.
- R5: With the enable high and a captured rate code of 2'b10, `clk_val` is bit 14 of the edge counter. It changes once every 16384 reference rising edges, with 50% duty.
- R6: A captured rate code of 2'b11 behaves exactly like 2'b00 and gives the full reference rate.
- R7: Reset clears the edge counter and sets the captured rate code to 2'b00. Until the first reference rising edge after reset, the output follows the reference whatever `rate_sel` holds. During reset both outputs are 0.
- R8: `rate_sel` is captured only on a detected reference rising edge. A change of code neither resets nor disturbs the edge counter, so the new rate picks up at the counter's current phase.
- R9: The edge counter adds exactly one per reference rising edge and wraps from 32767 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| osc_in | input | 1 | 32.768 kHz reference square wave, asynchronous |
| en_in | input | 1 | Output enable request, asynchronous; low turns the output off |
| rate_sel | input | 2 | Rate code: 00/11 full rate, 01 1024 Hz, 10 1 Hz |
| clk_val | output | 1 | Clock output value, 0 while off |
| clk_oe | output | 1 | Output drive enable; 0 models high impedance |

## Verification
The divider assertions assume that every level of the reference lasts at least two system clocks, so that each rising edge produces exactly one tick. The stimulus therefore drives `osc_in` with half-periods of two or three system clocks. The enable-follow assertion assumes nothing about `en_in`. It is armed only after two clocks out of reset, and the bench toggles the enable at arbitrary points, including mid reference period. Rate codes are changed at arbitrary cycles as well, since the design must tolerate a change at any time and apply it only on the next rising edge.

// File: rtl/rate_clkout_pkg.sv
package rate_clkout_pkg;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'b00,
    RATE_KILO    = 2'b01,
    RATE_SECOND  = 2'b10,
    RATE_FULL_ALT = 2'b11
  } rate_e;

  // Output level chosen for a rate code from the reference level and divider taps.
  function automatic logic pick_level(input rate_e code, input logic ref_lvl,
                                      input logic tap_lo, input logic tap_hi);
    logic lvl;
    unique case (code)
      RATE_KILO:   lvl = tap_lo;
      RATE_SECOND: lvl = tap_hi;
      default:     lvl = ref_lvl;
    endcase
    return lvl;
  endfunction

  // Rising-edge test between a current and previous sample.
  function automatic logic is_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/rate_clkout_sync.sv
module rate_clkout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rate_clkout_div.sv
module rate_clkout_div #(
  parameter int DIV_W  = 15,
  parameter int LO_TAP = 4,
  parameter int HI_TAP = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_lvl,
  output logic             tick,
  output logic             tap_lo,
  output logic             tap_hi,
  output logic [DIV_W-1:0] count
);
  import rate_clkout_pkg::*;

  logic ref_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= ref_lvl;
  end

  assign tick = is_rise(ref_lvl, ref_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  assign tap_lo = count[LO_TAP];
  assign tap_hi = count[HI_TAP];

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + DIV_W'(1));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R4
  lo_tap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap_lo) |-> count[LO_TAP-1:0] == '0);

  // R5
  hi_tap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap_hi) |-> count[HI_TAP-1:0] == '0);
endmodule

// File: rtl/rate_clkout_sel.sv
module rate_clkout_sel (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [1:0]            sel_in,
  input  logic                  ref_lvl,
  input  logic                  tap_lo,
  input  logic                  tap_hi,
  output rate_clkout_pkg::rate_e code_q,
  output logic                  out_raw
);
  import rate_clkout_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= RATE_FULL;
    else if (tick) code_q <= rate_e'(sel_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_raw <= 1'b0;
    else        out_raw <= pick_level(code_q, ref_lvl, tap_lo, tap_hi);
  end

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(code_q));
endmodule

// File: rtl/rate_clkout.sv
module rate_clkout #(
  parameter int DIV_W  = 15,
  parameter int LO_TAP = 4,
  parameter int HI_TAP = 14,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_in,
  input  logic       en_in,
  input  logic [1:0] rate_sel,
  output logic       clk_val,
  output logic       clk_oe
);
  import rate_clkout_pkg::*;

  logic             ref_lvl;
  logic             en_sync;
  logic             ref_tick;
  logic             tap_lo;
  logic             tap_hi;
  logic [DIV_W-1:0] div_count;
  rate_e            code_q;
  logic             out_raw;

  rate_clkout_sync #(.STAGES(SYNC_N)) u_osc_sync (
    .clk(clk), .rst_n(rst_n), .d_async(osc_in), .q_sync(ref_lvl)
  );

  rate_clkout_sync #(.STAGES(SYNC_N)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d_async(en_in), .q_sync(en_sync)
  );

  rate_clkout_div #(.DIV_W(DIV_W), .LO_TAP(LO_TAP), .HI_TAP(HI_TAP)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .tick(ref_tick),
    .tap_lo(tap_lo), .tap_hi(tap_hi), .count(div_count)
  );

  rate_clkout_sel u_sel (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .sel_in(rate_sel),
    .ref_lvl(ref_lvl), .tap_lo(tap_lo), .tap_hi(tap_hi),
    .code_q(code_q), .out_raw(out_raw)
  );

  assign clk_oe  = en_sync;
  assign clk_val = out_raw & en_sync;

  // cycles since reset release, saturating, arms the enable-follow check
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> clk_oe == $past(en_in, 2));
endmodule

// File: tb/rate_clkout_bench.sv
module rate_clkout_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_in = 1'b0;
  logic       en_in = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       clk_val;
  logic       clk_oe;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R7";
  bit    done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rate_clkout u_rate_clkout (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .en_in(en_in),
    .rate_sel(rate_sel), .clk_val(clk_val), .clk_oe(clk_oe)
  );

  // ---------------- reference model ----------------
  bit osc_hist[$];
  bit en_hist[$];
  int edges;
  int code;
  bit exp_raw;
  bit exp_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      osc_hist = '{1'b0, 1'b0, 1'b0, 1'b0};
      en_hist  = '{1'b0, 1'b0};
      edges = 0; code = 0; exp_raw = 1'b0; exp_oe = 1'b0;
    end else begin
      osc_hist.push_front(osc_in); void'(osc_hist.pop_back());
      en_hist.push_front(en_in);   void'(en_hist.pop_back());
      if (code == 1)      exp_raw = ((edges / 16) % 2) == 1;
      else if (code == 2) exp_raw = ((edges / 16384) % 2) == 1;
      else                exp_raw = osc_hist[2];
      if (osc_hist[2] && !osc_hist[3]) begin
        edges = (edges + 1) % 32768;
        code  = int'(rate_sel);
      end
      exp_oe = en_hist[1];
    end
  end

  task automatic check(input logic act, input logic expv, input string what);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check(clk_oe, 1'b0, "R7 reset oe");
        check(clk_val, 1'b0, "R7 reset val");
      end else begin
        check(clk_oe, exp_oe, "clk_oe");
        check(clk_val, exp_oe & exp_raw, "clk_val");
      end
    end
  end

  // ---------------- stimulus ----------------
  int half = 2;
  int phase_cnt = 0;

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      phase_cnt++;
      if (phase_cnt >= half) begin
        phase_cnt = 0;
        osc_in = ~osc_in;
      end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    en_in = 1'b1; rate_sel = 2'b01;
    tag = "R7";
    run(10);
    @(negedge clk); rst_n = 1'b1;
    run(40);                       // R7: full rate until first captured edge, then 01

    tag = "R1";
    en_in = 1'b0;
    for (int s = 0; s < 4; s++) begin rate_sel = 2'(s); run(75); end

    tag = "R2";
    rate_sel = 2'b00;
    for (int k = 0; k < 20; k++) begin en_in = ~en_in; run(3 + (k % 7)); end
    en_in = 1'b1;

    tag = "R3";
    half = 3; rate_sel = 2'b00; run(300);
    tag = "R6";
    rate_sel = 2'b11; run(300);
    half = 2;

    tag = "R4";
    rate_sel = 2'b01; run(2000);

    tag = "R8";
    for (int k = 0; k < 12; k++) begin
      rate_sel = (k % 2 == 0) ? 2'b10 : 2'b01;
      run(37 + 5 * k);
    end
    rate_sel = 2'b11; run(1); rate_sel = 2'b01; run(150);

    tag = "R5 R9";
    rate_sel = 2'b10; run(136000);
    tag = "R4 R9";
    rate_sel = 2'b01; run(500);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule